// File: doc/BRIEF.md
# Binary32 NaN Result Selector

This block computes the NaN result of a two-input binary32 arithmetic operation when at least one operand is a NaN. Each operand is sorted into quiet NaN, signaling NaN or ordinary value. One operand is then picked under one of four priority schemes, chosen per operation by a select input. If the picked operand is signaling, it is returned with its quiet bit set. The block also reports an invalid-operation flag whenever either operand is signaling.

A default-NaN mode input replaces the propagated payload with a fixed canonical NaN. The invalid flag is still computed as usual in that mode. A build-time parameter gives a variant for cores that have no signaling NaNs. In that variant every NaN counts as quiet.

The selection logic is purely combinational. Its results are captured in output registers, so each answer appears one clock after its operands. Non-NaN arithmetic results are produced elsewhere. When neither operand is a NaN, this block only lowers its valid output.

Top module: `nan_prop_sel`

## Requirements
- R1: An operand is a NaN when its exponent field (bits 30:23) is all ones and its fraction (bits 22:0) is nonzero. A NaN with bit 22 set is quiet, and one with bit 22 clear is signaling. An infinity (fraction zero) is not a NaN.
- R2: With rule select 0, the picked operand is the first match in this order: a if signaling, then b if signaling, then a if quiet, and otherwise b.
- R3: With rule select 1, a is picked if it is any NaN; otherwise b is picked.
- R4: With rule select 2, a quiet NaN beats a signaling NaN, and a lone NaN beats an ordinary value. When both NaNs are of the same kind, the one with the larger bits 30:0 wins. If bits 30:0 are equal, the operand whose full 32-bit word is smaller as an unsigned number wins, which is the one with sign bit 0.
- R5: With rule select 3, b is picked if it is any NaN; otherwise a is picked.
- R6: If the picked operand is signaling, the result is that operand with bit 22 forced to 1. All its other bits are unchanged. A quiet picked operand is passed through unchanged.
- R7: invalid_o is 1 exactly when at least one operand is a signaling NaN. This holds in default-NaN mode as well.
- R8: When default_nan_mode_i is 1 and a NaN is present, the result is 32'hFFC00000, whatever operand the rule would pick.
- R9: When neither operand is a NaN, nan_valid_o is 0, invalid_o is 0 and result_o is 0.
- R10: The outputs are registered. Operands applied before a rising clock edge show on the outputs after that edge. A synchronous reset clears all outputs to 0.
- R11: With NO_SNAN set to 1, every NaN counts as quiet. The operand is then returned unchanged, even with bit 22 clear, and invalid_o stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| rule_i | input | 2 | Priority scheme select: 0 signaling-first, 1 a-first, 2 larger-significand, 3 b-first |
| default_nan_mode_i | input | 1 | Return the canonical NaN instead of a propagated one |
| result_o | output | 32 | Registered NaN result |
| invalid_o | output | 1 | Registered invalid-operation flag |
| nan_valid_o | output | 1 | Registered: at least one operand was a NaN |

## Verification
The bench instantiates the block twice with the default 8-bit exponent and 23-bit fraction. The first instance has NO_SNAN=0 and the second has NO_SNAN=1. The first instance covers all four priority schemes, the quieting of a signaling pick and the default-NaN override with invalid still raised. It also covers the sign tie-break between NaNs with equal magnitudes and infinities that must not count as NaNs. The second instance shows that a signaling-looking NaN comes back untouched and raises no flag.

// File: rtl/nanp_pkg.sv
package nanp_pkg;
  typedef enum logic [1:0] {
    PICK_SIG_FIRST = 2'd0,
    PICK_A_FIRST   = 2'd1,
    PICK_LARGER    = 2'd2,
    PICK_B_FIRST   = 2'd3
  } pick_rule_e;

  typedef struct packed {
    logic is_nan;
    logic is_quiet;
    logic is_sig;
  } nan_class_t;
endpackage

// File: rtl/nanp_classify.sv
module nanp_classify
  import nanp_pkg::*;
#(
  parameter int EXP_W   = 8,
  parameter int MAN_W   = 23,
  parameter bit NO_SNAN = 1'b0
) (
  input  logic [EXP_W+MAN_W:0] word_i,
  output nan_class_t           cls_o
);
  localparam int W = 1 + EXP_W + MAN_W;

  logic exp_ones, frac_nz, qbit, nan;

  always_comb begin
    exp_ones = &word_i[W-2:MAN_W];
    frac_nz  = |word_i[MAN_W-1:0];
    qbit     = word_i[MAN_W-1];
    nan      = exp_ones && frac_nz;
  end

  generate
    if (NO_SNAN) begin : g_all_quiet
      assign cls_o = '{is_nan: nan, is_quiet: nan, is_sig: 1'b0};
    end else begin : g_ieee
      assign cls_o = '{is_nan: nan, is_quiet: nan && qbit, is_sig: nan && !qbit};
    end
  endgenerate

  always_comb begin
    AST_CLASS_EXCLUSIVE: assert (!(cls_o.is_quiet && cls_o.is_sig)); // R1
  end
endmodule

// File: rtl/nanp_pick.sv
module nanp_pick
  import nanp_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  nan_class_t   ca_i,
  input  nan_class_t   cb_i,
  input  pick_rule_e   rule_i,
  output logic         sel_b_o
);
  logic a_larger;

  always_comb begin
    if (a_i[W-2:0] > b_i[W-2:0])      a_larger = 1'b1;
    else if (a_i[W-2:0] < b_i[W-2:0]) a_larger = 1'b0;
    else                              a_larger = (a_i < b_i);
  end

  always_comb begin
    unique case (rule_i)
      PICK_SIG_FIRST: begin
        if (ca_i.is_sig)        sel_b_o = 1'b0;
        else if (cb_i.is_sig)   sel_b_o = 1'b1;
        else if (ca_i.is_quiet) sel_b_o = 1'b0;
        else                    sel_b_o = 1'b1;
      end
      PICK_A_FIRST: sel_b_o = !ca_i.is_nan;
      PICK_LARGER: begin
        if (ca_i.is_sig) begin
          if (cb_i.is_sig) sel_b_o = !a_larger;
          else             sel_b_o = cb_i.is_quiet;
        end else if (ca_i.is_quiet) begin
          if (cb_i.is_quiet) sel_b_o = !a_larger;
          else               sel_b_o = 1'b0;
        end else begin
          sel_b_o = 1'b1;
        end
      end
      PICK_B_FIRST: sel_b_o = cb_i.is_nan;
      default:      sel_b_o = 1'b0;
    endcase
  end

  always_comb begin
    AST_PICK_A_FIRST: assert (!(rule_i == PICK_A_FIRST && ca_i.is_nan && sel_b_o)); // R3
    AST_PICK_B_FIRST: assert (!(rule_i == PICK_B_FIRST && cb_i.is_nan && !sel_b_o)); // R5
  end
endmodule

// File: rtl/nan_prop_sel.sv
module nan_prop_sel
  import nanp_pkg::*;
#(
  parameter int EXP_W   = 8,
  parameter int MAN_W   = 23,
  parameter bit NO_SNAN = 1'b0
) (
  input  logic                   clk_i,
  input  logic                   rst_i,
  input  logic [EXP_W+MAN_W:0]   a_i,
  input  logic [EXP_W+MAN_W:0]   b_i,
  input  logic [1:0]             rule_i,
  input  logic                   default_nan_mode_i,
  output logic [EXP_W+MAN_W:0]   result_o,
  output logic                   invalid_o,
  output logic                   nan_valid_o
);
  localparam int W = 1 + EXP_W + MAN_W;
  localparam logic [W-1:0] QBIT    = {{(W-MAN_W){1'b0}}, 1'b1, {(MAN_W-1){1'b0}}};
  localparam logic [W-1:0] DEF_NAN = {1'b1, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

  nan_class_t   ca, cb;
  logic         sel_b, pick_sig, any_nan, any_sig;
  logic [W-1:0] picked, quieted, res_d;

  nanp_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W), .NO_SNAN(NO_SNAN)) u_cls_a (
    .word_i(a_i), .cls_o(ca)
  );
  nanp_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W), .NO_SNAN(NO_SNAN)) u_cls_b (
    .word_i(b_i), .cls_o(cb)
  );
  nanp_pick #(.W(W)) u_pick (
    .a_i(a_i), .b_i(b_i), .ca_i(ca), .cb_i(cb),
    .rule_i(pick_rule_e'(rule_i)), .sel_b_o(sel_b)
  );

  always_comb begin
    picked   = sel_b ? b_i : a_i;
    pick_sig = sel_b ? cb.is_sig : ca.is_sig;
    quieted  = pick_sig ? (picked | QBIT) : picked;
    any_nan  = ca.is_nan || cb.is_nan;
    any_sig  = ca.is_sig || cb.is_sig;
    if (!any_nan)                res_d = '0;
    else if (default_nan_mode_i) res_d = DEF_NAN;
    else                         res_d = quieted;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      result_o    <= '0;
      invalid_o   <= 1'b0;
      nan_valid_o <= 1'b0;
    end else begin
      result_o    <= res_d;
      invalid_o   <= any_sig;
      nan_valid_o <= any_nan;
    end
  end

  AST_OUT_IS_QUIET: assert property (@(posedge clk_i) disable iff (rst_i)
    nan_valid_o |-> ((NO_SNAN != 0) || (&result_o[W-2:MAN_W-1]))); // R6
  AST_INVALID_NEEDS_NAN: assert property (@(posedge clk_i) disable iff (rst_i)
    invalid_o |-> nan_valid_o); // R7
  AST_DEFAULT_PATTERN: assert property (@(posedge clk_i) disable iff (rst_i)
    (nan_valid_o && $past(default_nan_mode_i) && !$past(rst_i)) |-> (result_o == DEF_NAN)); // R8
  AST_NO_NAN_IDLE: assert property (@(posedge clk_i) disable iff (rst_i)
    ($past(!(&a_i[W-2:MAN_W])) && $past(!(&b_i[W-2:MAN_W])))
      |-> (!nan_valid_o && !invalid_o && result_o == '0)); // R9
  AST_NOSNAN_NO_INVALID: assert property (@(posedge clk_i) disable iff (rst_i)
    (NO_SNAN != 0) |-> !invalid_o); // R11
endmodule

// File: tb/tb_nan_prop_sel.sv
module tb_nan_prop_sel;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] a = '0, b = '0;
  logic [1:0]  rule = '0;
  logic        dnm = 1'b0;
  logic [31:0] res, res_q;
  logic        inv, inv_q, val, val_q;
  int          n_run = 0, n_fail = 0;

  always #2 clk = ~clk;

  nan_prop_sel dut (
    .clk_i(clk), .rst_i(rst), .a_i(a), .b_i(b), .rule_i(rule),
    .default_nan_mode_i(dnm), .result_o(res), .invalid_o(inv), .nan_valid_o(val)
  );
  nan_prop_sel #(.NO_SNAN(1'b1)) dut_nq (
    .clk_i(clk), .rst_i(rst), .a_i(a), .b_i(b), .rule_i(rule),
    .default_nan_mode_i(dnm), .result_o(res_q), .invalid_o(inv_q), .nan_valid_o(val_q)
  );

  // {rule[100:99], dnm[98], a[97:66], b[65:34], result[33:2], invalid[1], valid[0]}
  localparam int NV = 22;
  localparam logic [100:0] VEC [NV] = '{
    {2'd0, 1'b0, 32'h7F800005, 32'h7FC00010, 32'h7FC00005, 1'b1, 1'b1},
    {2'd0, 1'b0, 32'h7FC00001, 32'hFF800003, 32'hFFC00003, 1'b1, 1'b1},
    {2'd0, 1'b0, 32'h7FC00001, 32'h7FD00000, 32'h7FC00001, 1'b0, 1'b1},
    {2'd0, 1'b0, 32'h3F800000, 32'h7FD00000, 32'h7FD00000, 1'b0, 1'b1},
    {2'd1, 1'b0, 32'h7FC00001, 32'h7F800003, 32'h7FC00001, 1'b1, 1'b1},
    {2'd1, 1'b0, 32'h3F800000, 32'h7F800003, 32'h7FC00003, 1'b1, 1'b1},
    {2'd2, 1'b0, 32'h7F800005, 32'h7FC00002, 32'h7FC00002, 1'b1, 1'b1},
    {2'd2, 1'b0, 32'h7FC00001, 32'h7FA00000, 32'h7FC00001, 1'b1, 1'b1},
    {2'd2, 1'b0, 32'h7FC00001, 32'h7FC00009, 32'h7FC00009, 1'b0, 1'b1},
    {2'd2, 1'b0, 32'h7F800100, 32'h7F800010, 32'h7FC00100, 1'b1, 1'b1},
    {2'd2, 1'b0, 32'hFFC00004, 32'h7FC00004, 32'h7FC00004, 1'b0, 1'b1},
    {2'd2, 1'b0, 32'h7FC00004, 32'hFFC00004, 32'h7FC00004, 1'b0, 1'b1},
    {2'd2, 1'b0, 32'h3F800000, 32'h7F800001, 32'h7FC00001, 1'b1, 1'b1},
    {2'd2, 1'b0, 32'hFFC00007, 32'h40000000, 32'hFFC00007, 1'b0, 1'b1},
    {2'd3, 1'b0, 32'h7FC00001, 32'h7FC00002, 32'h7FC00002, 1'b0, 1'b1},
    {2'd3, 1'b0, 32'h7F800001, 32'h3F800000, 32'h7FC00001, 1'b1, 1'b1},
    {2'd0, 1'b1, 32'h7F800001, 32'h3F800000, 32'hFFC00000, 1'b1, 1'b1},
    {2'd1, 1'b1, 32'h7FC00001, 32'h7FC00002, 32'hFFC00000, 1'b0, 1'b1},
    {2'd0, 1'b0, 32'h3F800000, 32'h40000000, 32'h00000000, 1'b0, 1'b0},
    {2'd2, 1'b0, 32'h7F800000, 32'hFF800000, 32'h00000000, 1'b0, 1'b0},
    {2'd0, 1'b0, 32'h7F800000, 32'h7F800009, 32'h7FC00009, 1'b1, 1'b1},
    {2'd3, 1'b1, 32'h00000000, 32'h7FFFFFFF, 32'hFFC00000, 1'b0, 1'b1}
  };
  localparam logic [23:0] TAG [NV] = '{
    " R2", " R2", " R2", " R2", " R3", " R3", " R4", " R4", " R4", " R4", " R4",
    " R4", " R4", " R4", " R5", " R5", " R7", " R8", " R9", " R1", " R6", " R8"
  };

  task automatic check(input logic [23:0] tag, input logic [31:0] r, input logic iv,
                       input logic vl, input logic [31:0] er, input logic ei, input logic ev);
    n_run++;
    if (r !== er || iv !== ei || vl !== ev) begin
      n_fail++;
      $display("FAIL %s: got res=%h inv=%b val=%b, expected res=%h inv=%b val=%b",
               tag, r, iv, vl, er, ei, ev);
    end
  endtask

  task automatic apply(input logic [100:0] v);
    @(negedge clk);
    rule = v[100:99]; dnm = v[98]; a = v[97:66]; b = v[65:34];
    @(negedge clk);
  endtask

  initial begin
    #(4 * 100000);
    n_fail++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    a = 32'h7F800001; b = 32'h7F800001;
    repeat (3) @(negedge clk);
    check(" R10", res, inv, val, 32'h0, 1'b0, 1'b0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i]);
      check(TAG[i], res, inv, val, VEC[i][33:2], VEC[i][1], VEC[i][0]);
    end

    // R10: new operands do not show before the next rising edge
    @(negedge clk);
    rule = 2'd0; dnm = 1'b0; a = 32'h7F800002; b = 32'h0;
    #1;
    check(" R10", res, inv, val, 32'hFFC00000, 1'b0, 1'b1);
    @(negedge clk);
    check(" R10", res, inv, val, 32'h7FC00002, 1'b1, 1'b1);

    // R11: all NaNs quiet in the no-signaling variant
    apply({2'd0, 1'b0, 32'h7F800005, 32'h3F800000, 32'h0, 1'b0, 1'b0});
    check("R11", res_q, inv_q, val_q, 32'h7F800005, 1'b0, 1'b1);
    apply({2'd2, 1'b0, 32'h7F800005, 32'h7FC00001, 32'h0, 1'b0, 1'b0});
    check("R11", res_q, inv_q, val_q, 32'h7FC00001, 1'b0, 1'b1);

    // R10: synchronous reset mid-run with NaN operands present
    @(negedge clk);
    rst = 1'b1; a = 32'h7F800001; b = 32'h7F800003;
    @(negedge clk);
    check(" R10", res, inv, val, 32'h0, 1'b0, 1'b0);
    rst = 1'b0;

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule